// File: doc/BRIEF.md
# Synchronous Serial Shift Unit

This block moves one byte at a time over a two-wire synchronous link made of a bidirectional data line and a shift clock that the block always drives. Writing a byte through the parallel port while the unit is idle starts a transmit. The byte leaves least significant bit first. Every bit, the first one included, sits on the data line while the clock is still high, so it is settled before the falling edge that the far end samples on.

Setting the receive enable while the unit is idle and the receive-done flag is clear starts a receive. The unit produces the same eight clock periods, samples the data line on each falling edge, and loads the assembled byte into a read buffer. Each direction has its own done flag. A flag stays set until a clear pulse removes it. No start, stop or parity bits are added.

Top module: `ssm_unit`

## Requirements
- R1: A write (`wr_en` high) while idle starts a transmit. From the clock edge that accepts the write, `sdata_oe` is 1, `sdata_out` carries bit 0 of the written byte, and `sclk_out` is still high, so the first bit is valid before the first falling edge.
- R2: A transfer moves exactly 8 bits, least significant first. Bit k is driven during the k-th clock period, counting from 0. No framing bits are added.
- R3: `sclk_out` is 1 when idle. Each bit period lasts BIT_CLKS system clocks: BIT_CLKS/2 clocks high, then BIT_CLKS/2 clocks low. The falling edge is the sampling edge.
- R4: During a transmit, `sdata_out` changes only on the edge where `sclk_out` rises. It never changes while `sclk_out` is low.
- R5: A receive starts when `rx_en` is 1, the unit is idle, no write is present and `rx_done` is 0. `sdata_in` is captured on each of the 8 falling edges, first sample into bit 0. After the last period, `rd_data` holds the captured byte.
- R6: On the edge that ends the eighth bit period, `tx_done` or `rx_done` is set to match the direction, and `sclk_out` returns high. A flag stays 1 until its clear input is pulsed. If a set and a clear arrive on the same edge, the set wins.
- R7: `sdata_oe` is 1 only during a transmit. It is 0 during a receive, when idle, and after a transmit ends. After a transmit, `sdata_out` keeps its last bit.
- R8: A write that arrives while a transfer is in progress is ignored. The bits on the line and the received byte are unaffected.
- R9: While `rx_done` is 1, a held-high `rx_en` does not start a new receive.
- R10: If `wr_en` and a valid receive start occur on the same edge, the transmit is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | W | Byte to transmit |
| rx_en | input | 1 | Receive enable |
| clr_tx_done | input | 1 | Clear pulse for tx_done |
| clr_rx_done | input | 1 | Clear pulse for rx_done |
| sdata_in | input | 1 | Data line as seen at the pin |
| rd_data | output | W | Last received byte |
| tx_done | output | 1 | Transmit finished flag |
| rx_done | output | 1 | Receive finished flag |
| sdata_out | output | 1 | Data line output value |
| sdata_oe | output | 1 | Data line output enable |
| sclk_out | output | 1 | Shift clock, idles high |

## Verification
The bench focuses on the first transmitted bit. A design that drives the LSB only after the first falling edge shows the wrong data level in the cycles just after the write is accepted. A write issued in the middle of a transfer is included; a design that reloads on it corrupts the remaining bits. The bench holds `rx_en` high after a receive finishes; a design that ignores the done flag would start clocking again. A write that coincides with a receive start is included; a design that gives the receive priority would leave `sdata_oe` low.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
   typedef enum logic {
      XFER_TX = 1'b0,
      XFER_RX = 1'b1
   } xfer_e;
endpackage

// File: rtl/ssm_timing.sv
module ssm_timing #(
   parameter int W        = 8,
   parameter int BIT_CLKS = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic fall_now,
   output logic rise_now,
   output logic last_now,
   output logic sclk
);
   localparam int HALF = BIT_CLKS / 2;
   localparam int CW   = $clog2(BIT_CLKS);
   localparam int BW   = $clog2(W);

   logic [CW-1:0] cnt;
   logic [BW-1:0] bidx;
   logic          wrap;

   assign wrap     = (cnt == CW'(BIT_CLKS - 1));
   assign fall_now = run && (cnt == CW'(HALF - 1));
   assign last_now = run && wrap && (bidx == BW'(W - 1));
   assign rise_now = run && wrap && (bidx != BW'(W - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         bidx <= '0;
         sclk <= 1'b1;
      end else begin
         if (start) begin
            cnt  <= '0;
            bidx <= '0;
         end else if (run) begin
            if (wrap) begin
               cnt  <= '0;
               bidx <= bidx + BW'(1);
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
         if (fall_now)
            sclk <= 1'b0;
         else if (run && wrap)
            sclk <= 1'b1;
      end
   end
endmodule

// File: rtl/ssm_shifter.sv
module ssm_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         tx_shift,
   input  logic         rx_shift,
   input  logic [W-1:0] par_in,
   input  logic         ser_in,
   output logic [W-1:0] sr_q,
   output logic         ser_out
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         sr_q <= '0;
      else if (load)
         sr_q <= par_in;
      else if (tx_shift)
         sr_q <= {1'b0, sr_q[W-1:1]};
      else if (rx_shift)
         sr_q <= {ser_in, sr_q[W-1:1]};
   end

   assign ser_out = sr_q[0];
endmodule

// File: rtl/ssm_unit.sv
module ssm_unit
   import ssm_pkg::*;
#(
   parameter int W        = 8,
   parameter int BIT_CLKS = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rx_en,
   input  logic         clr_tx_done,
   input  logic         clr_rx_done,
   input  logic         sdata_in,
   output logic [W-1:0] rd_data,
   output logic         tx_done,
   output logic         rx_done,
   output logic         sdata_out,
   output logic         sdata_oe,
   output logic         sclk_out
);
   generate
      if (BIT_CLKS < 4 || (BIT_CLKS % 2) != 0) begin : g_bad_period
         initial $fatal(1, "BIT_CLKS must be even and at least 4");
      end
      if (W < 2) begin : g_bad_width
         initial $fatal(1, "W must be at least 2");
      end
   endgenerate

   logic    busy;
   xfer_e   mode;
   logic    rx_mode;
   logic    start_tx, start_rx, start;
   logic    fall_now, rise_now, last_now;
   logic [W-1:0] sr_q;

   assign rx_mode  = (mode == XFER_RX);
   assign start_tx = !busy && wr_en;
   assign start_rx = !busy && !wr_en && rx_en && !rx_done;
   assign start    = start_tx || start_rx;

   ssm_timing #(.W(W), .BIT_CLKS(BIT_CLKS)) u_timing (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .run      (busy),
      .fall_now (fall_now),
      .rise_now (rise_now),
      .last_now (last_now),
      .sclk     (sclk_out)
   );

   ssm_shifter #(.W(W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start_tx),
      .tx_shift (rise_now && !rx_mode),
      .rx_shift (fall_now && rx_mode),
      .par_in   (wr_data),
      .ser_in   (sdata_in),
      .sr_q     (sr_q),
      .ser_out  (sdata_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         mode     <= XFER_TX;
         sdata_oe <= 1'b0;
         tx_done  <= 1'b0;
         rx_done  <= 1'b0;
         rd_data  <= '0;
      end else begin
         if (start) begin
            busy <= 1'b1;
            mode <= start_tx ? XFER_TX : XFER_RX;
         end else if (last_now) begin
            busy <= 1'b0;
         end

         if (start_tx)
            sdata_oe <= 1'b1;
         else if (last_now)
            sdata_oe <= 1'b0;

         if (last_now && !rx_mode)
            tx_done <= 1'b1;
         else if (clr_tx_done)
            tx_done <= 1'b0;

         if (last_now && rx_mode)
            rx_done <= 1'b1;
         else if (clr_rx_done)
            rx_done <= 1'b0;

         if (last_now && rx_mode)
            rd_data <= sr_q;
      end
   end
endmodule

// File: rtl/ssm_unit_chk.sv
module ssm_unit_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         wr_en,
   input logic [W-1:0] wr_data,
   input logic         clr_tx_done,
   input logic         tx_done,
   input logic         rx_done,
   input logic         sdata_out,
   input logic         sdata_oe,
   input logic         sclk_out,
   input logic         busy,
   input logic         rx_mode
);
   AST_FIRST_BIT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdata_oe) |-> (sdata_out == $past(wr_data[0])) && sclk_out); // R1

   AST_DATA_STILL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sdata_oe && !sclk_out) |-> $stable(sdata_out)); // R4

   AST_TX_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_done) |-> sclk_out && !sdata_oe); // R6

   AST_RX_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rx_mode) |-> !sdata_oe); // R7

   AST_TX_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && !clr_tx_done) |=> tx_done); // R6

   AST_RX_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !busy && !wr_en) |=> !busy); // R9

   AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy)) |-> sclk_out); // R3
endmodule

bind ssm_unit ssm_unit_chk #(.W(W)) u_chk (.*);

// File: tb/ssm_unit_test.sv
`timescale 1ns/1ps
module ssm_unit_test;
   localparam int W        = 8;
   localparam int BIT_CLKS = 12;
   localparam int HALF     = BIT_CLKS / 2;
   localparam int XFER     = W * BIT_CLKS;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         rx_en = 1'b0;
   logic         clr_tx_done = 1'b0;
   logic         clr_rx_done = 1'b0;
   logic         sdata_in = 1'b0;
   logic [W-1:0] rd_data;
   logic         tx_done, rx_done, sdata_out, sdata_oe, sclk_out;

   ssm_unit #(.W(W), .BIT_CLKS(BIT_CLKS)) uut (.*);

   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;

   // behavioural reference state
   int           m_busy = 0;
   int           m_rx   = 0;
   int           m_el   = 0;
   logic [W-1:0] m_txb  = '0;
   logic [W-1:0] m_acc  = '0;
   logic [W-1:0] m_rd   = '0;
   logic         m_txd  = 1'b0;
   logic         m_rxd  = 1'b0;
   logic         m_last = 1'b0;
   logic [W-1:0] rx_pat = '0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_rx = 0; m_el = 0; m_txb = '0; m_acc = '0;
         m_rd = '0; m_txd = 1'b0; m_rxd = 1'b0; m_last = 1'b0;
      end else begin
         logic old_rxd;
         old_rxd = m_rxd;
         if (clr_tx_done) m_txd = 1'b0;
         if (clr_rx_done) m_rxd = 1'b0;
         if (m_busy != 0) begin
            if (m_rx != 0 && (m_el % BIT_CLKS) == HALF - 1)
               m_acc[m_el / BIT_CLKS] = sdata_in;
            m_el++;
            if (m_el == XFER) begin
               m_busy = 0;
               if (m_rx != 0) begin m_rxd = 1'b1; m_rd = m_acc; end
               else begin m_txd = 1'b1; m_last = m_txb[W-1]; end
            end
         end else if (wr_en) begin
            m_busy = 1; m_rx = 0; m_el = 0; m_txb = wr_data;
         end else if (rx_en && !old_rxd) begin
            m_busy = 1; m_rx = 1; m_el = 0;
         end
      end
   end

   // per-cycle comparison and line stimulus, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R3", "sclk_out", int'(sclk_out),
             (m_busy != 0) ? int'((m_el % BIT_CLKS) < HALF) : 1);
         chk("R7", "sdata_oe", int'(sdata_oe), int'(m_busy != 0 && m_rx == 0));
         if (m_busy != 0 && m_rx == 0)
            chk("R2", "sdata_out", int'(sdata_out), int'(m_txb[m_el / BIT_CLKS]));
         chk("R6", "tx_done", int'(tx_done), int'(m_txd));
         chk("R6", "rx_done", int'(rx_done), int'(m_rxd));
         chk("R5", "rd_data", int'(rd_data), int'(m_rd));
      end
      if (m_busy != 0 && m_rx != 0)
         sdata_in <= rx_pat[m_el / BIT_CLKS];
      else
         sdata_in <= 1'b0;
   end

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_write(input logic [W-1:0] b);
      wr_data = b; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      cycles(4);
      chk("R3", "reset sclk", int'(sclk_out), 1);
      chk("R7", "reset oe", int'(sdata_oe), 0);
      rst_n = 1'b1;
      cycles(2);

      // R1: first bit present right after the write, clock still high
      pulse_write(8'hA5);
      chk("R1", "oe after write", int'(sdata_oe), 1);
      chk("R1", "bit0 after write", int'(sdata_out), 1);
      chk("R1", "clk high at start", int'(sclk_out), 1);
      cycles(20);
      pulse_write(8'hFF);          // R8: ignored mid-transfer
      cycles(XFER);
      chk("R6", "tx_done held", int'(tx_done), 1);
      chk("R7", "last bit held", int'(sdata_out), int'(m_last));
      clr_tx_done = 1'b1; @(negedge clk); clr_tx_done = 1'b0;
      chk("R6", "tx_done cleared", int'(tx_done), 0);

      pulse_write(8'h01);          // R2: LSB first
      chk("R2", "lsb first", int'(sdata_out), 1);
      cycles(XFER + 2);
      clr_tx_done = 1'b1; @(negedge clk); clr_tx_done = 1'b0;

      // R5: receive
      rx_pat = 8'h3C; rx_en = 1'b1;
      cycles(XFER + 3);
      chk("R5", "rx byte", int'(rd_data), 8'h3C);
      cycles(40);                  // R9: rx_en still high, no restart
      chk("R9", "idle clock", int'(sclk_out), 1);
      chk("R9", "rx byte kept", int'(rd_data), 8'h3C);

      rx_pat = 8'hC3;
      clr_rx_done = 1'b1; @(negedge clk); clr_rx_done = 1'b0;
      cycles(30);
      pulse_write(8'h55);          // R8: ignored during receive
      chk("R8", "no drive in rx", int'(sdata_oe), 0);
      cycles(XFER);
      chk("R5", "second rx byte", int'(rd_data), 8'hC3);
      chk("R6", "tx_done not set", int'(tx_done), 0);

      // R10: write wins over receive start
      rx_en = 1'b0;
      clr_rx_done = 1'b1; @(negedge clk); clr_rx_done = 1'b0;
      rx_en = 1'b1;
      pulse_write(8'h80);
      rx_en = 1'b0;
      chk("R10", "tx chosen", int'(sdata_oe), 1);
      cycles(XFER + 4);
      chk("R10", "tx_done", int'(tx_done), 1);
      chk("R10", "rx_done", int'(rx_done), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule